// File: doc/BRIEF.md
# Receive Character Queue with Error Tagging

This block holds received serial characters for one channel between the receive shifter and the CPU. Every stored character keeps its own parity-error, framing-error and break tags, so an error reaches software together with the character that caused it. The block also derives the channel's receive status from the queue: data present, a programmable fill threshold, a timeout for characters left unread, an overrun flag, a sticky error summary and a request line for a DMA engine.

The receive shifter offers one complete character per `pushValid` pulse. The CPU side removes the head with `popReq`, clears the sticky flags with `statusRead`, and empties the queue with the one-cycle `flush` strobe. Character timing comes from a 16x baud tick and the current frame length.

Top module: `rxq_buffer`

## Requirements
- R1: The queue holds up to DEPTH (16) entries of 8 data bits plus parity, framing and break tags, and returns them in arrival order. `headData` and the three `head*` tags show the oldest entry. They read zero while the queue is empty, and a pop of an empty queue does nothing. `dataReady` is 1 whenever at least one entry is stored.
- R2: `trigHit` is 1 while the stored count is at least the level chosen by `trigCode`: 0→1, 1→4, 2→8, 3→14. It drops as soon as the count falls below that level.
- R3: When at least one entry is stored and neither a push nor a pop occurs, `timeoutFlag` rises on the 64×`frameBits`-th baud tick, which is four character times of 16 ticks per frame bit. It never rises while the queue is empty.
- R4: A pop clears a pending timeout and restarts the timer. While no timeout is pending, every push and every pop also restarts the timer. A push while a timeout is pending leaves it set.
- R5: A character offered while the queue is full and no pop occurs in the same cycle is discarded, and `overrun` is 1 from the following cycle. `overrun` never rises while the queue has room, and a `statusRead` clears it.
- R6: `errSummary` becomes 1 when an entry carrying any error tag is stored. It stays at 1 while such an entry is stored. A `statusRead` clears it only when no stored entry carries an error.
- R7: A character offered with the break tag is stored as data 0x00 with `headBrk` = 1, whatever its data bits are.
- R8: `flush` empties the queue within one cycle and cancels any pending timeout. A push or pop in the same cycle is ignored.
- R9: With `dmaMode` = 0, `rxReady` equals `dataReady`.
- R10: With `dmaMode` = 1, `rxReady` goes to 1 when the trigger level is reached or a timeout is pending, and stays at 1 until the queue is empty.
- R11: A push and a pop in the same cycle are both carried out, even when the queue is full. The count is unchanged and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Complete character offered by the shifter |
| pushData | input | 8 | Character data |
| pushPar | input | 1 | Parity error tag |
| pushFrm | input | 1 | Framing error tag |
| pushBrk | input | 1 | Break tag |
| popReq | input | 1 | CPU removes the head entry |
| statusRead | input | 1 | CPU status read; clears sticky flags |
| flush | input | 1 | One-cycle queue clear |
| baudTick | input | 1 | 16x baud enable |
| frameBits | input | 4 | Frame length in bits |
| trigCode | input | 2 | Trigger level select |
| dmaMode | input | 1 | 0: single transfer, 1: burst request |
| headData | output | 8 | Oldest stored data |
| headPar | output | 1 | Parity tag of head |
| headFrm | output | 1 | Framing tag of head |
| headBrk | output | 1 | Break tag of head |
| dataReady | output | 1 | At least one entry stored |
| overrun | output | 1 | Character lost to a full queue |
| errSummary | output | 1 | Sticky error summary |
| trigHit | output | 1 | Count at or above trigger level |
| timeoutFlag | output | 1 | Character timeout pending |
| rxReady | output | 1 | DMA receive request |

## Verification
The assertions check on every cycle that the count stays within the depth, that a flush empties the queue, that a simultaneous push and pop keep the count, and that overrun rises only from a full queue. They also check that a timeout is never pending on an empty queue, that stored errors keep the summary set, and that a reached trigger always raises the request. Exact timeout tick counts, arrival order through a full queue, which character is dropped on overrun, the break data replacement and the clearing rules of the sticky flags depend on specific sequences, and only the directed scenarios of the bench show them.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } rxq_strobe_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxq_strobe_t      stb,
  input  rxq_entry_t       wrEntry,
  output logic [CNT_W-1:0] count,
  output rxq_entry_t       head,
  output logic             errAny
);
  rxq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] errCount;
  logic             wrErr, headErr;

  assign wrErr   = wrEntry.par | wrEntry.frm | wrEntry.brk;
  assign head    = (count != '0) ? mem[rdPtr] : '0;
  assign headErr = head.par | head.frm | head.brk;
  assign errAny  = (errCount != '0);

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      errCount <= '0;
    end else if (stb.flush) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      errCount <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + 1'b1;
      if (stb.pop)  rdPtr <= rdPtr + 1'b1;
      case ({stb.push, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      errCount <= errCount + CNT_W'(stb.push & wrErr) - CNT_W'(stb.pop & headErr);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> count == '0); // R8
  AST_PUSHPOP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && stb.pop && !stb.flush) |=> $stable(count)); // R11
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int FB_W       = 4,
  parameter int TICK_LOG2  = 4,
  parameter int CHARS_LOG2 = 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SHIFT = TICK_LOG2 + CHARS_LOG2,
  localparam int TMR_W = FB_W + SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             pushErr,
  input  logic             popReq,
  input  logic             flushReq,
  input  logic             statusRead,
  input  logic             baudTick,
  input  logic [FB_W-1:0]  frameBits,
  input  logic [1:0]       trigCode,
  input  logic             dmaMode,
  input  logic [CNT_W-1:0] count,
  input  logic             errAny,
  output rxq_strobe_t      stb,
  output logic             overrun,
  output logic             errSummary,
  output logic             trigHit,
  output logic             timeoutFlag,
  output logic             rxReady
);
  logic             empty, full, drop, rdyLatch;
  logic [CNT_W-1:0] trigLevel;
  logic [TMR_W-1:0] tmr, tmrNext, limit;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  always_comb begin
    stb.flush = flushReq;
    stb.pop   = popReq & ~empty & ~flushReq;
    stb.push  = pushValid & (~full | stb.pop) & ~flushReq;
    drop      = pushValid & full & ~stb.pop & ~flushReq;
  end

  always_comb begin
    case (trigCode)
      2'd0:    trigLevel = CNT_W'(1);
      2'd1:    trigLevel = CNT_W'(4);
      2'd2:    trigLevel = CNT_W'(8);
      default: trigLevel = CNT_W'(14);
    endcase
  end
  assign trigHit = (count >= trigLevel);

  assign limit   = TMR_W'(frameBits) << SHIFT;
  assign tmrNext = tmr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr         <= '0;
      timeoutFlag <= 1'b0;
    end else if (stb.flush || empty || stb.pop) begin
      tmr         <= '0;
      timeoutFlag <= 1'b0;
    end else if (stb.push && !timeoutFlag) begin
      tmr <= '0;
    end else if (baudTick && !timeoutFlag) begin
      tmr <= tmrNext;
      if (tmrNext >= limit) timeoutFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun    <= 1'b0;
      errSummary <= 1'b0;
      rdyLatch   <= 1'b0;
    end else begin
      if (drop)            overrun <= 1'b1;
      else if (statusRead) overrun <= 1'b0;
      if (stb.push && pushErr)        errSummary <= 1'b1;
      else if (statusRead && !errAny) errSummary <= 1'b0;
      if (empty)                        rdyLatch <= 1'b0;
      else if (trigHit || timeoutFlag)  rdyLatch <= 1'b1;
    end
  end

  assign rxReady = dmaMode ? (~empty & (rdyLatch | trigHit | timeoutFlag)) : ~empty;

  AST_OVERRUN_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && full && !popReq && !flushReq) |=> overrun); // R5
  AST_OVERRUN_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (!overrun && !full) |=> !overrun); // R5
  AST_TIMEOUT_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |-> !empty); // R3
  AST_ERRSUM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    errAny |-> errSummary); // R6
  AST_TRIG_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    trigHit |-> rxReady); // R10
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pushPar,
  input  logic              pushFrm,
  input  logic              pushBrk,
  input  logic              popReq,
  input  logic              statusRead,
  input  logic              flush,
  input  logic              baudTick,
  input  logic [FB_W-1:0]   frameBits,
  input  logic [1:0]        trigCode,
  input  logic              dmaMode,
  output logic [DATA_W-1:0] headData,
  output logic              headPar,
  output logic              headFrm,
  output logic              headBrk,
  output logic              dataReady,
  output logic              overrun,
  output logic              errSummary,
  output logic              trigHit,
  output logic              timeoutFlag,
  output logic              rxReady
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rxq_strobe_t      stb;
  rxq_entry_t       wrEntry, head;
  logic [CNT_W-1:0] count;
  logic             errAny;

  always_comb begin
    wrEntry.brk  = pushBrk;
    wrEntry.frm  = pushFrm;
    wrEntry.par  = pushPar;
    wrEntry.data = pushBrk ? '0 : pushData;
  end

  rxq_ctrl #(.DEPTH(DEPTH), .FB_W(FB_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid),
    .pushErr(pushPar | pushFrm | pushBrk), .popReq(popReq),
    .flushReq(flush), .statusRead(statusRead), .baudTick(baudTick),
    .frameBits(frameBits), .trigCode(trigCode), .dmaMode(dmaMode),
    .count(count), .errAny(errAny), .stb(stb), .overrun(overrun),
    .errSummary(errSummary), .trigHit(trigHit),
    .timeoutFlag(timeoutFlag), .rxReady(rxReady)
  );

  rxq_store #(.DEPTH(DEPTH)) uStore (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEntry(wrEntry),
    .count(count), .head(head), .errAny(errAny)
  );

  assign headData  = head.data;
  assign headPar   = head.par;
  assign headFrm   = head.frm;
  assign headBrk   = head.brk;
  assign dataReady = (count != '0);
endmodule

// File: tb/tb_rxq_buffer.sv
module tb_rxq_buffer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic pushValid = 0, pushPar = 0, pushFrm = 0, pushBrk = 0;
  logic [7:0] pushData = 0;
  logic popReq = 0, statusRead = 0, flush = 0, baudTick = 0, dmaMode = 0;
  logic [3:0] frameBits = 4'd10;
  logic [1:0] trigCode = 2'd0;
  logic [7:0] headData;
  logic headPar, headFrm, headBrk, dataReady, overrun, errSummary;
  logic trigHit, timeoutFlag, rxReady;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_buffer dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .pushPar(pushPar), .pushFrm(pushFrm), .pushBrk(pushBrk), .popReq(popReq),
    .statusRead(statusRead), .flush(flush), .baudTick(baudTick),
    .frameBits(frameBits), .trigCode(trigCode), .dmaMode(dmaMode),
    .headData(headData), .headPar(headPar), .headFrm(headFrm), .headBrk(headBrk),
    .dataReady(dataReady), .overrun(overrun), .errSummary(errSummary),
    .trigHit(trigHit), .timeoutFlag(timeoutFlag), .rxReady(rxReady)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pushChar(logic [7:0] d, logic p = 0, logic f = 0, logic b = 0);
    pushValid = 1; pushData = d; pushPar = p; pushFrm = f; pushBrk = b;
    @(posedge clk); @(negedge clk);
    pushValid = 0; pushPar = 0; pushFrm = 0; pushBrk = 0;
  endtask

  task automatic popChar();
    popReq = 1; @(posedge clk); @(negedge clk); popReq = 0;
  endtask

  task automatic pushPop(logic [7:0] d);
    pushValid = 1; pushData = d; popReq = 1;
    @(posedge clk); @(negedge clk);
    pushValid = 0; popReq = 0;
  endtask

  task automatic readStatus();
    statusRead = 1; @(posedge clk); @(negedge clk); statusRead = 0;
  endtask

  task automatic doFlush();
    flush = 1; @(posedge clk); @(negedge clk); flush = 0;
  endtask

  task automatic testReset();
    check("R1 reset dataReady", dataReady, 0);
    check("R5 reset overrun", overrun, 0);
    check("R6 reset errSummary", errSummary, 0);
    check("R3 reset timeout", timeoutFlag, 0);
    check("R9 reset rxReady", rxReady, 0);
    popChar();
    check("R1 pop on empty ignored", dataReady, 0);
  endtask

  task automatic testTrigger();
    int lvl [4] = '{1, 4, 8, 14};
    for (int c = 0; c < 4; c++) begin
      doFlush();
      trigCode = 2'(c);
      for (int i = 0; i < lvl[c] - 1; i++) pushChar(8'(i));
      check("R2 below level", trigHit, 0);
      pushChar(8'hAA);
      check("R2 at level", trigHit, 1);
      popChar();
      check("R2 drops below level", trigHit, 0);
    end
    doFlush();
  endtask

  task automatic testOverrunOrder();
    for (int i = 0; i < 16; i++) pushChar(8'h10 + 8'(i));
    check("R5 full no overrun", overrun, 0);
    pushChar(8'hEE);
    check("R5 overrun on full", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      check("R1 arrival order", headData, 8'h10 + i);
      popChar();
    end
    check("R5 extra char dropped", dataReady, 0);
    check("R1 empty head zero", headData, 0);
    readStatus();
    check("R5 status read clears", overrun, 0);
    for (int i = 0; i < 16; i++) pushChar(8'h20 + 8'(i));
    pushPop(8'h99);
    check("R11 no overrun on push+pop", overrun, 0);
    check("R11 head advanced", headData, 8'h21);
    for (int i = 0; i < 15; i++) popChar();
    check("R11 pushed char kept", headData, 8'h99);
    popChar();
    check("R11 count unchanged", dataReady, 0);
  endtask

  task automatic testErrors();
    pushChar(8'h01);
    pushChar(8'h02, 1, 0, 0);
    check("R1 head tag clean", headPar, 0);
    check("R6 summary set", errSummary, 1);
    popChar();
    check("R1 parity tag at head", headPar, 1);
    readStatus();
    check("R6 read keeps summary while stored", errSummary, 1);
    popChar();
    check("R6 summary sticky after pop", errSummary, 1);
    readStatus();
    check("R6 read clears summary", errSummary, 0);
    pushChar(8'h5A, 0, 0, 1);
    check("R7 break data zero", headData, 0);
    check("R7 break tag", headBrk, 1);
    readStatus();
    doFlush();
    check("R8 flush empties", dataReady, 0);
    readStatus();
    check("R6 cleared after flush and read", errSummary, 0);
  endtask

  task automatic testTimeout();
    frameBits = 4'd10; trigCode = 2'd3; dmaMode = 1;
    pushChar(8'h33);
    check("R10 below trigger no request", rxReady, 0);
    baudTick = 1;
    repeat (639) @(posedge clk);
    @(negedge clk);
    check("R3 no timeout before limit", timeoutFlag, 0);
    @(posedge clk); @(negedge clk);
    check("R3 timeout at limit", timeoutFlag, 1);
    check("R10 timeout raises request", rxReady, 1);
    pushChar(8'h34);
    check("R4 push keeps pending timeout", timeoutFlag, 1);
    popChar();
    check("R4 pop clears timeout", timeoutFlag, 0);
    check("R10 request held until empty", rxReady, 1);
    repeat (639) @(posedge clk);
    @(negedge clk);
    check("R4 timer restarted by pop", timeoutFlag, 0);
    @(posedge clk); @(negedge clk);
    check("R4 timeout after restart", timeoutFlag, 1);
    doFlush();
    check("R8 flush cancels timeout", timeoutFlag, 0);
    @(posedge clk); @(negedge clk);
    check("R3 no timeout when empty", timeoutFlag, 0);
    baudTick = 0;
  endtask

  task automatic testDma();
    dmaMode = 0; trigCode = 2'd1;
    pushChar(8'h01);
    check("R9 mode0 request with one byte", rxReady, 1);
    popChar();
    check("R9 mode0 no request empty", rxReady, 0);
    dmaMode = 1;
    pushChar(8'h01);
    check("R10 mode1 below trigger", rxReady, 0);
    for (int i = 0; i < 3; i++) pushChar(8'(i));
    check("R10 mode1 trigger reached", rxReady, 1);
    popChar();
    check("R10 mode1 held below trigger", rxReady, 1);
    for (int i = 0; i < 3; i++) popChar();
    check("R10 mode1 released on empty", rxReady, 0);
    pushChar(8'h07);
    check("R10 mode1 re-armed", rxReady, 0);
    doFlush();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testTrigger();
    testOverrunOrder();
    testErrors();
    testTimeout();
    testDma();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule